// File: doc/BRIEF.md
# Writeback-Intensity Region Predictor

This block is a small, fully associative table that learns which instruction addresses cause many dirty-line writebacks to main memory. When the page allocator first touches a page, it asks the table about the instruction responsible. The answer is one bit. A high value means the page should be placed in the memory region that is quick to write. A low value means it should go to the region that is quick to read.

There are two ports.

- **Update port.** The cache controller pulses it on every writeback, with the program counter of the instruction that last stored to the line. On a hit, the matching entry's saturating counter is bumped. On a miss, a new entry is allocated with its counter set to one.
- **Query port.** It takes a program counter and returns a registered prediction one cycle later. An entry counts as write-intensive when its counter is at or above the `wr_thresh` input. The threshold is sampled in the same cycle as the query.

Every clock, the update decoder picks one of three named actions:

- `ACT_IDLE`: no update is requested.
- `ACT_BUMP`: the update PC hits; the entry's counter increments and saturates.
- `ACT_FILL`: the update PC misses; a victim entry is overwritten.

The victim is the lowest-index invalid entry if one exists. Otherwise it is the valid entry with the smallest count, with ties going to the lower index.

Top module: `wbp_predictor`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) invalidates every entry and drives `resp_valid` and `resp_fast_write` low. With an empty table, every query returns `resp_fast_write` = 0.
- R2: `resp_valid` is high in exactly the cycles that follow a clock edge at which `qry_valid` was sampled high.
- R3: A query whose PC matches a valid entry returns `resp_fast_write` = 1 when that entry's count is greater than or equal to `wr_thresh`, and 0 otherwise.
- R4: A query whose PC matches no valid entry returns `resp_fast_write` = 0.
- R5: An update whose PC matches a valid entry raises that entry's count by exactly one.
- R6: A count that has reached 2^CNT_W-1 stays there on further hits and does not wrap.
- R7: An update that misses while some entry is invalid installs the PC in the lowest-index invalid entry, with a count of 1.
- R8: An update that misses on a full table replaces the entry with the smallest count, choosing the lowest index on a tie. The new entry's count is 1, and the evicted PC then misses.
- R9: When an update and a query for the same PC arrive in the same cycle, the query is judged on the count as it stood before that update.
- R10: A change to `wr_thresh` applies to the very next query, with no table update needed.
- R11: Asserting reset in the middle of operation discards all learned entries, so previously write-intensive PCs return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| upd_valid | input | 1 | Writeback update strobe |
| upd_pc | input | PC_W | PC of the instruction that last wrote the written-back line |
| wr_thresh | input | CNT_W | Count at or above which a PC is judged write-intensive |
| qry_valid | input | 1 | Prediction request strobe |
| qry_pc | input | PC_W | PC to look up |
| resp_valid | output | 1 | Prediction valid, one cycle after the request |
| resp_fast_write | output | 1 | 1 = place page in fast-write region, 0 = fast-read region |

## Verification
The bench builds the table with four entries, 16-bit PCs and 4-bit counters. With 4-bit counters, saturation at 15 is reached after a handful of writebacks, so a wrap-around fault would flip a prediction within a few cycles. The bench cycles six distinct PCs through four entries, which forces repeated evictions, including a deliberately constructed tie between two lowest counts. Same-cycle update and query of one PC, threshold changes between back-to-back queries, and a reset taken mid-run are each driven explicitly. A random phase then follows, compared cycle by cycle against the behavioural model.

// File: rtl/wbp_pkg.sv
package wbp_pkg;
    typedef enum logic [1:0] {
        ACT_IDLE = 2'd0,
        ACT_BUMP = 2'd1,
        ACT_FILL = 2'd2
    } upd_act_e;
endpackage

// File: rtl/wbp_match.sv
// Associative lookup: finds the valid entry whose PC equals the key.
module wbp_match #(
    parameter int ENTRIES = 4,
    parameter int PC_W    = 32,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic [ENTRIES-1:0]           ent_valid,
    input  logic [ENTRIES-1:0][PC_W-1:0] ent_pc,
    input  logic [PC_W-1:0]              key,
    output logic                         hit,
    output logic [IDX_W-1:0]             idx
);
    logic [ENTRIES-1:0] eq;

    generate
        for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
            assign eq[g] = ent_valid[g] && (ent_pc[g] == key);
        end
    endgenerate

    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (eq[i] && !hit) begin
                hit = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/wbp_victim.sv
// Victim choice: first invalid entry, else smallest count (lowest index on ties).
module wbp_victim #(
    parameter int ENTRIES = 4,
    parameter int CNT_W   = 16,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic [ENTRIES-1:0]            ent_valid,
    input  logic [ENTRIES-1:0][CNT_W-1:0] ent_cnt,
    output logic [IDX_W-1:0]              victim
);
    logic             free_seen;
    logic [CNT_W-1:0] best_cnt;

    always_comb begin
        victim    = '0;
        free_seen = 1'b0;
        best_cnt  = '1;
        for (int i = 0; i < ENTRIES; i++) begin
            if (!free_seen) begin
                if (!ent_valid[i]) begin
                    free_seen = 1'b1;
                    victim    = IDX_W'(i);
                end else if (i == 0 || ent_cnt[i] < best_cnt) begin
                    victim   = IDX_W'(i);
                    best_cnt = ent_cnt[i];
                end
            end
        end
    end
endmodule

// File: rtl/wbp_predictor.sv
module wbp_predictor
    import wbp_pkg::*;
#(
    parameter int ENTRIES = 4,
    parameter int PC_W    = 32,
    parameter int CNT_W   = 16,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
    localparam logic [CNT_W-1:0] CNT_MAX = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             upd_valid,
    input  logic [PC_W-1:0]  upd_pc,
    input  logic [CNT_W-1:0] wr_thresh,
    input  logic             qry_valid,
    input  logic [PC_W-1:0]  qry_pc,
    output logic             resp_valid,
    output logic             resp_fast_write
);
    logic [ENTRIES-1:0]            valid_q;
    logic [ENTRIES-1:0][PC_W-1:0]  pc_q;
    logic [ENTRIES-1:0][CNT_W-1:0] cnt_q;

    logic             upd_hit, qry_hit;
    logic [IDX_W-1:0] upd_idx, qry_idx, victim_idx;
    upd_act_e         act;
    logic             qry_fw;

    wbp_match #(.ENTRIES(ENTRIES), .PC_W(PC_W)) u_upd_match (
        .ent_valid (valid_q),
        .ent_pc    (pc_q),
        .key       (upd_pc),
        .hit       (upd_hit),
        .idx       (upd_idx)
    );

    wbp_match #(.ENTRIES(ENTRIES), .PC_W(PC_W)) u_qry_match (
        .ent_valid (valid_q),
        .ent_pc    (pc_q),
        .key       (qry_pc),
        .hit       (qry_hit),
        .idx       (qry_idx)
    );

    wbp_victim #(.ENTRIES(ENTRIES), .CNT_W(CNT_W)) u_victim (
        .ent_valid (valid_q),
        .ent_cnt   (cnt_q),
        .victim    (victim_idx)
    );

    // Update action decode
    always_comb begin
        if (!upd_valid)   act = ACT_IDLE;
        else if (upd_hit) act = ACT_BUMP;
        else              act = ACT_FILL;
    end

    // Table state
    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else begin
            unique case (act)
                ACT_IDLE: ;
                ACT_BUMP: begin
                    if (cnt_q[upd_idx] != CNT_MAX)
                        cnt_q[upd_idx] <= cnt_q[upd_idx] + 1'b1;
                end
                ACT_FILL: begin
                    valid_q[victim_idx] <= 1'b1;
                    pc_q[victim_idx]    <= upd_pc;
                    cnt_q[victim_idx]   <= CNT_W'(1);
                end
                default: ;
            endcase
        end
    end

    // Query response, judged on pre-update table contents
    assign qry_fw = qry_hit && (cnt_q[qry_idx] >= wr_thresh);

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_valid      <= 1'b0;
            resp_fast_write <= 1'b0;
        end else begin
            resp_valid      <= qry_valid;
            resp_fast_write <= qry_valid && qry_fw;
        end
    end
endmodule

// File: rtl/wbp_checker.sv
module wbp_checker #(
    parameter int ENTRIES = 4,
    parameter int PC_W    = 32,
    parameter int CNT_W   = 16,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input logic                            clk,
    input logic                            rst,
    input logic                            upd_valid,
    input logic [PC_W-1:0]                 upd_pc,
    input logic                            upd_hit,
    input logic [IDX_W-1:0]                upd_idx,
    input logic [IDX_W-1:0]                victim_idx,
    input logic                            qry_valid,
    input logic                            resp_valid,
    input logic                            resp_fast_write,
    input logic [ENTRIES-1:0]              ent_valid,
    input logic [ENTRIES-1:0][PC_W-1:0]    ent_pc,
    input logic [ENTRIES-1:0][CNT_W-1:0]   ent_cnt
);
    logic rst_d;
    always_ff @(posedge clk) rst_d <= rst;

    // R1: after a reset edge the table is empty and no response is pending
    always @(negedge clk) begin
        if (rst_d) begin
            a_r1_reset_clears: assert (ent_valid == '0 && !resp_valid && !resp_fast_write);
        end
    end

    a_r2_resp_tracks_query: assert property (@(posedge clk) disable iff (rst)
        qry_valid |=> resp_valid);

    a_r2_no_spurious_resp: assert property (@(posedge clk) disable iff (rst)
        !qry_valid |=> !resp_valid);

    a_r3_fw_needs_resp: assert property (@(posedge clk) disable iff (rst)
        resp_fast_write |-> resp_valid);

    generate
        for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
            // R7 / R8: an allocated entry holds the new PC with count one
            a_r8_fill_count_one: assert property (@(posedge clk) disable iff (rst)
                (upd_valid && !upd_hit && victim_idx == IDX_W'(g))
                |=> (ent_valid[g] && ent_cnt[g] == CNT_W'(1) && ent_pc[g] == $past(upd_pc)));

            // R5 / R6: a hit adds one, or holds at the ceiling
            a_r5_bump_by_one: assert property (@(posedge clk) disable iff (rst)
                (upd_valid && upd_hit && upd_idx == IDX_W'(g))
                |=> (ent_cnt[g] == $past(ent_cnt[g]) + 1'b1
                     || (ent_cnt[g] == '1 && $past(ent_cnt[g]) == '1)));

            // R6: a resident entry's count never decreases
            a_r6_no_wrap: assert property (@(posedge clk) disable iff (rst)
                (ent_valid[g] && $past(ent_valid[g]) && ent_pc[g] == $past(ent_pc[g])
                 && !$past(upd_valid && !upd_hit && victim_idx == IDX_W'(g)))
                |-> ent_cnt[g] >= $past(ent_cnt[g]));
        end
    endgenerate
endmodule

bind wbp_predictor wbp_checker #(.ENTRIES(ENTRIES), .PC_W(PC_W), .CNT_W(CNT_W)) u_chk (
    .clk             (clk),
    .rst             (rst),
    .upd_valid       (upd_valid),
    .upd_pc          (upd_pc),
    .upd_hit         (upd_hit),
    .upd_idx         (upd_idx),
    .victim_idx      (victim_idx),
    .qry_valid       (qry_valid),
    .resp_valid      (resp_valid),
    .resp_fast_write (resp_fast_write),
    .ent_valid       (valid_q),
    .ent_pc          (pc_q),
    .ent_cnt         (cnt_q)
);

// File: tb/wbp_predictor_bench.sv
module wbp_predictor_bench;
    localparam int ENTRIES = 4;
    localparam int PC_W    = 16;
    localparam int CNT_W   = 4;
    localparam int CMAX    = (1 << CNT_W) - 1;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             upd_valid = 1'b0;
    logic [PC_W-1:0]  upd_pc = '0;
    logic [CNT_W-1:0] wr_thresh = '0;
    logic             qry_valid = 1'b0;
    logic [PC_W-1:0]  qry_pc = '0;
    logic             resp_valid, resp_fast_write;

    int errors = 0;
    int checks = 0;
    int thr = 0;

    // Behavioural model
    bit m_v   [ENTRIES];
    int m_pc  [ENTRIES];
    int m_cnt [ENTRIES];

    always #4 clk = ~clk;

    wbp_predictor #(.ENTRIES(ENTRIES), .PC_W(PC_W), .CNT_W(CNT_W)) u_wbp_predictor (
        .clk             (clk),
        .rst             (rst),
        .upd_valid       (upd_valid),
        .upd_pc          (upd_pc),
        .wr_thresh       (wr_thresh),
        .qry_valid       (qry_valid),
        .qry_pc          (qry_pc),
        .resp_valid      (resp_valid),
        .resp_fast_write (resp_fast_write)
    );

    function automatic bit model_query(input int pc, input int t);
        for (int i = 0; i < ENTRIES; i++)
            if (m_v[i] && m_pc[i] == pc) return (m_cnt[i] >= t);
        return 1'b0;
    endfunction

    function automatic void model_update(input int pc);
        int sel;
        int best;
        for (int i = 0; i < ENTRIES; i++) begin
            if (m_v[i] && m_pc[i] == pc) begin
                if (m_cnt[i] < CMAX) m_cnt[i]++;
                return;
            end
        end
        sel = -1;
        for (int i = 0; i < ENTRIES; i++)
            if (sel < 0 && !m_v[i]) sel = i;
        if (sel < 0) begin
            sel  = 0;
            best = m_cnt[0];
            for (int i = 1; i < ENTRIES; i++)
                if (m_cnt[i] < best) begin
                    sel  = i;
                    best = m_cnt[i];
                end
        end
        m_v[sel]   = 1'b1;
        m_pc[sel]  = pc;
        m_cnt[sel] = 1;
    endfunction

    function automatic void model_clear();
        for (int i = 0; i < ENTRIES; i++) m_v[i] = 1'b0;
    endfunction

    task automatic check(input string tag, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic step(input bit uv, input int upc, input bit qv, input int qpc, input string tag);
        bit exp_fw;
        @(negedge clk);
        upd_valid = uv;
        upd_pc    = PC_W'(upc);
        qry_valid = qv;
        qry_pc    = PC_W'(qpc);
        wr_thresh = CNT_W'(thr);
        exp_fw = qv && model_query(qpc, thr);   // R9: judged before the update
        if (uv) model_update(upc);
        @(posedge clk);
        #2;
        check(tag, resp_valid, qv, "resp_valid");
        check(tag, resp_fast_write, exp_fw, "resp_fast_write");
    endtask

    task automatic wb(input int pc, input int n);
        for (int k = 0; k < n; k++) step(1'b1, pc, 1'b0, 0, "R5");
    endtask

    task automatic ask(input int pc, input int t, input string tag);
        thr = t;
        step(1'b0, 0, 1'b1, pc, tag);
    endtask

    task automatic do_reset(input string tag);
        @(negedge clk);
        rst = 1'b1;
        upd_valid = 1'b0;
        qry_valid = 1'b0;
        @(posedge clk);
        #2;
        model_clear();
        check(tag, resp_valid, 1'b0, "resp_valid in reset");
        check(tag, resp_fast_write, 1'b0, "resp_fast_write in reset");
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        do_reset("R1");
        ask(16'h0100, 0, "R1");                 // empty table answers fast-read
        step(1'b0, 0, 1'b0, 0, "R2");           // no query, no response

        wb(16'h0100, 3);                        // R7: A -> entry 0, count 3
        ask(16'h0100, 3, "R3");                 // at threshold: fast-write
        ask(16'h0100, 4, "R3");                 // below threshold: fast-read
        ask(16'h0100, 2, "R10");                // threshold lowered, same count
        ask(16'h0999, 0, "R4");                 // absent PC: fast-read

        thr = 4;
        step(1'b1, 16'h0100, 1'b1, 16'h0100, "R9");  // sees 3 -> fast-read
        ask(16'h0100, 4, "R9");                      // now 4 -> fast-write

        wb(16'h0200, 20);                       // B saturates at 15
        ask(16'h0200, 15, "R6");
        ask(16'h0200, 5, "R6");

        wb(16'h0300, 2);                        // C count 2 (entry 2)
        wb(16'h0400, 1);                        // D count 1 (entry 3)
        wb(16'h0500, 1);                        // E evicts D (smallest)
        ask(16'h0400, 0, "R8");
        ask(16'h0500, 1, "R8");
        wb(16'h0500, 1);                        // E=2 ties with C=2
        wb(16'h0600, 1);                        // F evicts C (lower index)
        ask(16'h0300, 0, "R8");
        ask(16'h0500, 2, "R8");
        ask(16'h0600, 1, "R7");

        do_reset("R11");
        ask(16'h0200, 0, "R11");
        ask(16'h0100, 0, "R11");

        for (int n = 0; n < 400; n++) begin
            thr = $urandom_range(0, 6);
            step(1'($urandom_range(0, 1)), 16'h0100 + $urandom_range(0, 5) * 16'h10,
                 1'($urandom_range(0, 1)), 16'h0100 + $urandom_range(0, 5) * 16'h10, "R3");
        end

        finish_run();
    end
endmodule